// File: doc/BRIEF.md
# Planar Video Memory Raster Operation Unit

This block applies one raster operation to a single byte address across up to four bit-planes of video memory. Software programs an operation code, a colour byte (one bit per plane), a write-mask, a per-plane skip mask and one tile byte per plane through a small register port. Each trigger carries a byte address. For every plane that takes part, the block reads that plane's byte, works out the new byte, merges it under the write-mask and, if enabled, under an external compare-status byte, and writes it back.

The planes are handled one after the other, lowest index first. Each plane takes one read cycle and then one write cycle on a plain synchronous memory port. That port has one cycle of read latency. It carries a plane index and a composed byte address whose layout depends on the line mode. A one-cycle done pulse marks the end of every accepted trigger.

Top module: `plane_rop_unit`

## Requirements
- R1: After reset every register reads back as 0x00; `busy`, `done` and `mem_req` are low.
- R2: Register addresses: 0 command, 1 colour, 2 write-mask, 3 plane skip, 4+p tile byte of plane p (p = 0..3). Each one reads back the value last written to it; any other address reads 0x00.
- R3: Command bit 7 is the enable. While it is 0, a trigger causes no memory access and no done pulse.
- R4: Command bits 2:0 give the operation: 0 set, 1 clear, 2 OR, 3 AND, 4 XOR, 5 invert, 6 tile, 7 compare-only. Set writes 0xFF to a plane whose colour bit is 1 and 0x00 to a plane whose colour bit is 0. Clear writes 0x00.
- R5: OR, AND and XOR combine the old byte with 0xFF when the plane's colour bit is 1 and with 0x00 when it is 0. Invert writes the complement of the old byte.
- R6: Tile writes plane p's tile byte.
- R7: A write-mask bit of 1 keeps the old memory bit. A 0 lets the computed bit through.
- R8: Plane p takes part only if p < min(`plane_cnt`, 4) and skip-register bit p is 0.
- R9: A plane whose `multipage_mask` bit is set is neither read nor written.
- R10: With command bit 6 set, the byte written takes the old bit wherever `cmp_status` is 1 if command bit 5 is 1, or wherever `cmp_status` is 0 if command bit 5 is 0. The other bits come from the masked result.
- R11: With `mode_wide` = 1, `mem_addr` = p·2^15 + addr[14:0]. With `mode_wide` = 0, `mem_addr` = p·2^14 + addr[13:0].
- R12: Planes are serviced in ascending index order, each with a read and then a write to the same address. For n planes, `done` pulses for one cycle 2n+1 falling-edge samples after the trigger is driven, and `busy` covers the whole operation. A trigger that arrives while `busy` is high is ignored.
- R13: Operation 7, or a trigger with no planes taking part, makes no memory access and pulses `done` in the cycle after the trigger edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| trig_valid | input | 1 | Start an operation |
| trig_addr | input | 15 | Byte address inside a plane |
| mode_wide | input | 1 | 1: 15-bit plane span, 0: 14-bit |
| plane_cnt | input | 3 | Number of planes fitted (clamped to 4) |
| multipage_mask | input | 4 | Planes that are not accessible |
| cmp_status | input | 8 | Compare status byte used for gated write-back |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_plane | output | 2 | Plane of the access |
| mem_addr | output | 17 | Composed byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after the read |

## Verification
A trigger is sampled at one rising edge. The first read appears in the next cycle, and the write for that plane follows one cycle later. Read data comes back a cycle after the read, so it is valid in the write cycle. `done` is high in the cycle after the last write, which puts it 2n+1 falling-edge samples after the trigger is driven. The bench drives and samples only on falling edges. It counts those samples until `done`, compares the count against 2n+1, checks that `done` has dropped one sample later, and reads the logged writes only after `done`.

// File: rtl/plane_rop_pkg.sv
// Shared encodings of the planar raster operation unit.
// Assumes: register indices and command bit positions fixed by software.
package plane_rop_pkg;
    typedef enum logic [2:0] {
        OP_SET    = 3'd0,
        OP_CLEAR  = 3'd1,
        OP_OR     = 3'd2,
        OP_AND    = 3'd3,
        OP_XOR    = 3'd4,
        OP_INVERT = 3'd5,
        OP_TILE   = 3'd6,
        OP_CMPONLY = 3'd7
    } rop_op_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RD   = 2'd1,
        SQ_WR   = 2'd2
    } seq_state_e;

    localparam logic [3:0] RA_CMD   = 4'd0;
    localparam logic [3:0] RA_COLOR = 4'd1;
    localparam logic [3:0] RA_MASK  = 4'd2;
    localparam logic [3:0] RA_SKIP  = 4'd3;
    localparam logic [3:0] RA_TILE0 = 4'd4;

    localparam int CB_ENABLE = 7;
    localparam int CB_CMP_EN = 6;
    localparam int CB_CMP_INV = 5;
endpackage

// File: rtl/rop_regfile.sv
// Register file: command, colour, write-mask, plane skip and per-plane tile bytes.
// Assumes: single write port, combinational read, all registers clear on reset.
module rop_regfile
    import plane_rop_pkg::*;
#(
    parameter int DW  = 8,
    parameter int NPL = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [3:0]              addr,
    input  logic [DW-1:0]           wdata,
    output logic [DW-1:0]           rdata,
    output logic [DW-1:0]           cmd_o,
    output logic [DW-1:0]           color_o,
    output logic [DW-1:0]           mask_o,
    output logic [DW-1:0]           skip_o,
    output logic [NPL-1:0][DW-1:0]  tile_o
);
    // Control registers: clear on reset, load on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_o   <= '0;
            color_o <= '0;
            mask_o  <= '0;
            skip_o  <= '0;
        end else if (we) begin
            case (addr)
                RA_CMD:   cmd_o   <= wdata;
                RA_COLOR: color_o <= wdata;
                RA_MASK:  mask_o  <= wdata;
                RA_SKIP:  skip_o  <= wdata;
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NPL; g++) begin : g_tile
        // Tile byte of plane g: clear on reset, load on its own index.
        always_ff @(posedge clk) begin
            if (!rst_n)
                tile_o[g] <= '0;
            else if (we && addr == 4'(RA_TILE0 + g))
                tile_o[g] <= wdata;
        end
    end

    // Read-back mux; unused indices read zero.
    always_comb begin
        rdata = '0;
        if (addr == RA_CMD)   rdata = cmd_o;
        if (addr == RA_COLOR) rdata = color_o;
        if (addr == RA_MASK)  rdata = mask_o;
        if (addr == RA_SKIP)  rdata = skip_o;
        for (int i = 0; i < NPL; i++)
            if (addr == 4'(RA_TILE0 + i)) rdata = tile_o[i];
    end
endmodule

// File: rtl/rop_lane_alu.sv
// Byte datapath for one plane: operation, write-mask merge, compare gating.
// Assumes: old byte is the value just read from the same address.
module rop_lane_alu
    import plane_rop_pkg::*;
#(
    parameter int DW = 8
) (
    input  rop_op_e         op,
    input  logic            color_bit,
    input  logic [DW-1:0]   wmask,
    input  logic [DW-1:0]   tile,
    input  logic [DW-1:0]   old,
    input  logic            cmp_en,
    input  logic            cmp_inv,
    input  logic [DW-1:0]   cmp_st,
    output logic [DW-1:0]   result
);
    logic [DW-1:0] raw;
    logic [DW-1:0] merged;

    // Raw operation result before any masking.
    always_comb begin
        case (op)
            OP_SET:    raw = {DW{color_bit}};
            OP_CLEAR:  raw = '0;
            OP_OR:     raw = color_bit ? {DW{1'b1}} : old;
            OP_AND:    raw = color_bit ? old : '0;
            OP_XOR:    raw = color_bit ? ~old : old;
            OP_INVERT: raw = ~old;
            OP_TILE:   raw = tile;
            default:   raw = old;
        endcase
    end

    // Mask 1 keeps the memory bit, then optional compare-status gating.
    always_comb begin
        merged = (old & wmask) | (raw & ~wmask);
        if (!cmp_en)
            result = merged;
        else if (cmp_inv)
            result = (old & cmp_st) | (merged & ~cmp_st);
        else
            result = (old & ~cmp_st) | (merged & cmp_st);
    end
endmodule

// File: rtl/rop_sequencer.sv
// Walks the participating planes, one read cycle then one write cycle each.
// Assumes: memory returns read data one cycle after the read request.
module rop_sequencer
    import plane_rop_pkg::*;
#(
    parameter int NPL  = 4,
    parameter int PLW  = (NPL > 1) ? $clog2(NPL) : 1,
    parameter int HI_W = 15,
    parameter int LO_W = 14,
    parameter int MAW  = HI_W + PLW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic             enable,
    input  logic [NPL-1:0]   act_mask,
    input  logic [HI_W-1:0]  trig_addr,
    input  logic             wide,
    output logic             busy,
    output logic             done,
    output logic             mem_req,
    output logic             mem_we,
    output logic [PLW-1:0]   plane,
    output logic [MAW-1:0]   mem_addr
);
    seq_state_e     state;
    logic [NPL-1:0] pend;
    logic [NPL-1:0] pend_nx;
    logic [HI_W-1:0] addr_q;
    logic           wide_q;
    logic           start;

    function automatic logic [PLW-1:0] first_set(input logic [NPL-1:0] m);
        first_set = '0;
        for (int i = NPL - 1; i >= 0; i--)
            if (m[i]) first_set = PLW'(i);
    endfunction

    assign start   = trig && enable && (state == SQ_IDLE);
    assign pend_nx = pend & ~(NPL'(1) << plane);

    // Plane walk: latch address and mode, step read/write per pending plane.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SQ_IDLE;
            pend   <= '0;
            plane  <= '0;
            addr_q <= '0;
            wide_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SQ_IDLE: if (start) begin
                    addr_q <= trig_addr;
                    wide_q <= wide;
                    if (act_mask == '0) begin
                        done <= 1'b1;
                    end else begin
                        pend  <= act_mask;
                        plane <= first_set(act_mask);
                        state <= SQ_RD;
                    end
                end
                SQ_RD: state <= SQ_WR;
                SQ_WR: begin
                    if (pend_nx == '0) begin
                        pend  <= '0;
                        done  <= 1'b1;
                        state <= SQ_IDLE;
                    end else begin
                        pend  <= pend_nx;
                        plane <= first_set(pend_nx);
                        state <= SQ_RD;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Memory strobes and plane-banked address.
    always_comb begin
        busy     = (state != SQ_IDLE);
        mem_req  = (state == SQ_RD) || (state == SQ_WR);
        mem_we   = (state == SQ_WR);
        mem_addr = wide_q ? MAW'({plane, addr_q})
                          : MAW'({plane, addr_q[LO_W-1:0]});
    end

    // R3: the memory port is quiet whenever no operation runs.
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req) else $error("idle memory access");

    // R12: every read is followed at once by the write of the same address.
    p_rd_then_wr_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> (mem_req && mem_we && mem_addr == $past(mem_addr)))
        else $error("read not followed by write");

    // R12: done only reported once the unit is idle again.
    p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy) else $error("done while busy");
endmodule

// File: rtl/plane_rop_unit.sv
// Top: planar raster operation unit (registers, plane walk, byte datapath).
// Assumes: memory read latency of one cycle; registers are written while idle.
module plane_rop_unit
    import plane_rop_pkg::*;
#(
    parameter int DW   = 8,
    parameter int NPL  = 4,
    parameter int PLW  = (NPL > 1) ? $clog2(NPL) : 1,
    parameter int HI_W = 15,
    parameter int LO_W = 14,
    parameter int MAW  = HI_W + PLW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [3:0]      reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic            trig_valid,
    input  logic [HI_W-1:0] trig_addr,
    input  logic            mode_wide,
    input  logic [2:0]      plane_cnt,
    input  logic [NPL-1:0]  multipage_mask,
    input  logic [DW-1:0]   cmp_status,
    output logic            busy,
    output logic            done,
    output logic            mem_req,
    output logic            mem_we,
    output logic [PLW-1:0]  mem_plane,
    output logic [MAW-1:0]  mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata
);
    logic [DW-1:0]           cmd, color, wmask, skip;
    logic [NPL-1:0][DW-1:0]  tile;
    logic [NPL-1:0]          act_mask;
    logic [3:0]              cnt_eff;
    rop_op_e                 op;

    rop_regfile #(.DW(DW), .NPL(NPL)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .cmd_o(cmd),
        .color_o(color), .mask_o(wmask), .skip_o(skip), .tile_o(tile)
    );

    assign op      = rop_op_e'(cmd[2:0]);
    assign cnt_eff = (int'(plane_cnt) > NPL) ? 4'(NPL) : {1'b0, plane_cnt};

    for (genvar p = 0; p < NPL; p++) begin : g_act
        assign act_mask[p] = (4'(p) < cnt_eff) && !skip[p] && !multipage_mask[p]
                             && (op != OP_CMPONLY);
    end

    rop_sequencer #(.NPL(NPL), .PLW(PLW), .HI_W(HI_W), .LO_W(LO_W), .MAW(MAW)) u_seq (
        .clk(clk), .rst_n(rst_n), .trig(trig_valid), .enable(cmd[CB_ENABLE]),
        .act_mask(act_mask), .trig_addr(trig_addr), .wide(mode_wide),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we),
        .plane(mem_plane), .mem_addr(mem_addr)
    );

    rop_lane_alu #(.DW(DW)) u_alu (
        .op(op), .color_bit(color[mem_plane]), .wmask(wmask),
        .tile(tile[mem_plane]), .old(mem_rdata), .cmp_en(cmd[CB_CMP_EN]),
        .cmp_inv(cmd[CB_CMP_INV]), .cmp_st(cmp_status), .result(mem_wdata)
    );

    // R7: bits under a set mask bit are written back unchanged.
    p_mask_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (((mem_wdata ^ mem_rdata) & wmask) == '0))
        else $error("masked bit altered");

    // R10: with inverted sense, status 1 bits keep memory.
    p_cmp_keep_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && cmd[CB_CMP_EN] && cmd[CB_CMP_INV])
        |-> (((mem_wdata ^ mem_rdata) & cmp_status) == '0))
        else $error("compare-gated bit altered");

    // R10: with normal sense, status 0 bits keep memory.
    p_cmp_keep_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && cmd[CB_CMP_EN] && !cmd[CB_CMP_INV])
        |-> (((mem_wdata ^ mem_rdata) & ~cmp_status) == '0))
        else $error("compare-gated bit altered");

    // R3: no access starts while the enable bit is clear and the unit idles.
    p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd[CB_ENABLE] && !busy) |=> !mem_req)
        else $error("access while disabled");
endmodule

// File: tb/plane_rop_unit_bench.sv
`timescale 1ns/1ps
module plane_rop_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        trig_valid = 1'b0;
    logic [14:0] trig_addr = '0;
    logic        mode_wide = 1'b0;
    logic [2:0]  plane_cnt = 3'd4;
    logic [3:0]  multipage_mask = '0;
    logic [7:0]  cmp_status = '0;
    logic        busy, done, mem_req, mem_we;
    logic [1:0]  mem_plane;
    logic [16:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  rdq = '0;

    int checks = 0;
    int failures = 0;
    int cycle_no = 0;
    bit finished = 0;

    logic [7:0]  vmem [int];
    logic [3:0]  wmask_log;
    logic [16:0] waddr_log [4];
    logic [7:0]  wdata_log [4];
    int          wcount;
    int          last_pl;
    bit          order_ok;

    always #5 clk = ~clk;

    plane_rop_unit u_plane_rop_unit (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_valid(trig_valid),
        .trig_addr(trig_addr), .mode_wide(mode_wide), .plane_cnt(plane_cnt),
        .multipage_mask(multipage_mask), .cmp_status(cmp_status), .busy(busy),
        .done(done), .mem_req(mem_req), .mem_we(mem_we), .mem_plane(mem_plane),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(rdq)
    );

    function automatic logic [7:0] rdmem(input int a);
        logic [16:0] v = 17'(a);
        if (vmem.exists(a)) return vmem[a];
        return v[7:0] ^ v[15:8] ^ {7'd0, v[16]} ^ 8'h3C;
    endfunction

    // Memory model with one cycle of read latency, serviced on falling edges.
    always @(negedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                vmem[int'(mem_addr)] = mem_wdata;
                if (wcount > 0 && int'(mem_plane) <= last_pl) order_ok = 0;
                last_pl = int'(mem_plane);
                wcount++;
                wmask_log[mem_plane] = 1'b1;
                waddr_log[mem_plane] = mem_addr;
                wdata_log[mem_plane] = mem_wdata;
            end else begin
                rdq = rdmem(int'(mem_addr));
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycle_no++;
        if (cycle_no > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycle_no);
            summary();
        end
    end

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    function automatic logic [7:0] exp_byte(input logic [2:0] op, input logic c,
            input logic [7:0] msk, input logic [7:0] tl, input logic [7:0] old,
            input logic cen, input logic cinv, input logic [7:0] st);
        logic [7:0] raw, m;
        case (op)
            3'd0: raw = c ? 8'hFF : 8'h00;
            3'd1: raw = 8'h00;
            3'd2: raw = old | (c ? 8'hFF : 8'h00);
            3'd3: raw = old & (c ? 8'hFF : 8'h00);
            3'd4: raw = old ^ (c ? 8'hFF : 8'h00);
            3'd5: raw = ~old;
            3'd6: raw = tl;
            default: raw = old;
        endcase
        m = (old & msk) | (raw & ~msk);
        if (!cen) return m;
        if (cinv) return (old & st) | (m & ~st);
        return (old & ~st) | (m & st);
    endfunction

    task automatic run_case(input string req, input logic [7:0] cmd, input logic [7:0] col,
            input logic [7:0] msk, input logic [7:0] skp, input logic [31:0] tiles,
            input logic [2:0] cnt, input logic [3:0] mp, input logic wide,
            input logic [7:0] st, input logic [14:0] a, input bit retrig);
        logic [3:0]  exp_mask;
        logic [16:0] ea [4];
        logic [7:0]  ed [4];
        int          n, cyc, lim;
        bit          seen;
        wr_reg(4'd0, cmd); wr_reg(4'd1, col); wr_reg(4'd2, msk); wr_reg(4'd3, skp);
        for (int p = 0; p < 4; p++) wr_reg(4'(4 + p), tiles[8*p +: 8]);
        mode_wide = wide; plane_cnt = cnt; multipage_mask = mp; cmp_status = st;
        lim = (cnt > 3'd4) ? 4 : int'(cnt);
        n = 0; exp_mask = '0;
        for (int p = 0; p < 4; p++) begin
            ea[p] = wide ? 17'(p * 32768 + int'(a)) : 17'(p * 16384 + int'(a[13:0]));
            ed[p] = exp_byte(cmd[2:0], col[p], msk, tiles[8*p +: 8], rdmem(int'(ea[p])),
                             cmd[6], cmd[5], st);
            if (p < lim && !skp[p] && !mp[p] && cmd[2:0] != 3'd7 && cmd[7]) begin
                exp_mask[p] = 1'b1; n++;
            end
        end
        wmask_log = '0; wcount = 0; order_ok = 1; last_pl = -1;
        trig_valid = 1'b1; trig_addr = a;
        @(negedge clk);
        trig_valid = 1'b0;
        cyc = 1; seen = 0;
        while (cyc < 16) begin
            if (done) begin seen = 1; break; end
            if (retrig && cyc == 2) begin trig_valid = 1'b1; trig_addr = a ^ 15'h0101; end
            else trig_valid = 1'b0;
            @(negedge clk);
            cyc++;
        end
        trig_valid = 1'b0;
        check(seen == cmd[7], cmd[7] ? "R12" : "R3", "done seen", 32'(seen), 32'(cmd[7]));
        if (seen) begin
            check(cyc == 2 * n + 1, "R12", "done latency", cyc, 2 * n + 1);
            @(negedge clk);
            check(!done, "R12", "done one cycle", 32'(done), 0);
            check(!busy, "R12", "busy after done", 32'(busy), 0);
        end
        repeat (2) @(negedge clk);
        check(wmask_log == exp_mask, req, "planes written", 32'(wmask_log), 32'(exp_mask));
        check(order_ok, "R12", "ascending plane order", 32'(order_ok), 1);
        for (int p = 0; p < 4; p++) begin
            if (exp_mask[p] && wmask_log[p]) begin
                check(waddr_log[p] == ea[p], "R11", "plane address", 32'(waddr_log[p]), 32'(ea[p]));
                check(wdata_log[p] == ed[p], req, "written byte", 32'(wdata_log[p]), 32'(ed[p]));
            end
        end
    endtask

    initial begin
        void'($urandom(32'd7741));
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 8; i++) begin
            reg_addr = 4'(i);
            #1;
            check(reg_rdata == 8'h00, "R1", "reset register", 32'(reg_rdata), 0);
        end
        check(!busy && !done && !mem_req, "R1", "reset outputs", {busy, done, mem_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: register map readback
        for (int i = 0; i < 8; i++) wr_reg(4'(i), 8'(8'h11 * (i + 1)));
        for (int i = 0; i < 9; i++) begin
            reg_addr = 4'(i);
            #1;
            check(reg_rdata == ((i < 8) ? 8'(8'h11 * (i + 1)) : 8'h00), "R2", "readback",
                  32'(reg_rdata), (i < 8) ? 32'(8'h11 * (i + 1)) : 0);
        end
        @(negedge clk);
        // Directed corner cases
        run_case("R3", 8'h00, 8'h0F, 8'h00, 8'h00, 32'h0, 3'd4, 4'h0, 1'b1, 8'h00, 15'h0123, 0);
        run_case("R4", 8'h80, 8'h05, 8'h00, 8'h00, 32'h0, 3'd4, 4'h0, 1'b1, 8'h00, 15'h0200, 0);
        run_case("R4", 8'h81, 8'h0F, 8'h00, 8'h00, 32'h0, 3'd4, 4'h0, 1'b1, 8'h00, 15'h0201, 0);
        run_case("R5", 8'h82, 8'h03, 8'h00, 8'h00, 32'h0, 3'd4, 4'h0, 1'b1, 8'h00, 15'h0302, 0);
        run_case("R5", 8'h83, 8'h06, 8'h00, 8'h00, 32'h0, 3'd4, 4'h0, 1'b1, 8'h00, 15'h0303, 0);
        run_case("R5", 8'h84, 8'h09, 8'h00, 8'h00, 32'h0, 3'd4, 4'h0, 1'b1, 8'h00, 15'h0304, 0);
        run_case("R5", 8'h85, 8'h00, 8'h00, 8'h00, 32'h0, 3'd4, 4'h0, 1'b1, 8'h00, 15'h0305, 0);
        run_case("R6", 8'h86, 8'h00, 8'h00, 8'h00, 32'hA55A_C33C, 3'd4, 4'h0, 1'b1, 8'h00, 15'h0406, 0);
        run_case("R7", 8'h80, 8'h0F, 8'hF0, 8'h00, 32'h0, 3'd4, 4'h0, 1'b1, 8'h00, 15'h0507, 0);
        run_case("R8", 8'h80, 8'h0F, 8'h00, 8'h0A, 32'h0, 3'd4, 4'h0, 1'b1, 8'h00, 15'h0608, 0);
        run_case("R8", 8'h80, 8'h0F, 8'h00, 8'h00, 32'h0, 3'd2, 4'h0, 1'b1, 8'h00, 15'h0609, 0);
        run_case("R8", 8'h80, 8'h0F, 8'h00, 8'h00, 32'h0, 3'd7, 4'h0, 1'b1, 8'h00, 15'h060A, 0);
        run_case("R9", 8'h80, 8'h0F, 8'h00, 8'h00, 32'h0, 3'd4, 4'h5, 1'b1, 8'h00, 15'h070B, 0);
        run_case("R10", 8'hE0, 8'h0F, 8'h00, 8'h00, 32'h0, 3'd4, 4'h0, 1'b1, 8'hC3, 15'h080C, 0);
        run_case("R10", 8'hC1, 8'h00, 8'h00, 8'h00, 32'h0, 3'd4, 4'h0, 1'b1, 8'h3C, 15'h080D, 0);
        run_case("R11", 8'h85, 8'h00, 8'h00, 8'h00, 32'h0, 3'd4, 4'h0, 1'b0, 8'h00, 15'h7ABC, 0);
        run_case("R11", 8'h85, 8'h00, 8'h00, 8'h00, 32'h0, 3'd4, 4'h0, 1'b1, 8'h00, 15'h7ABC, 0);
        run_case("R12", 8'h84, 8'h0F, 8'h00, 8'h00, 32'h0, 3'd4, 4'h0, 1'b1, 8'h00, 15'h0910, 1);
        run_case("R13", 8'h87, 8'h0F, 8'h00, 8'h00, 32'h0, 3'd4, 4'h0, 1'b1, 8'h00, 15'h0A11, 0);
        run_case("R13", 8'h80, 8'h0F, 8'h00, 8'h0F, 32'h0, 3'd4, 4'h0, 1'b1, 8'h00, 15'h0A12, 0);
        // Random mix over all operations and modes
        for (int k = 0; k < 60; k++) begin
            run_case("R4", 8'($urandom) | 8'h80, 8'($urandom), 8'($urandom), 8'($urandom),
                     $urandom, 3'($urandom), 4'($urandom), 1'($urandom), 8'($urandom),
                     15'($urandom), 1'($urandom));
        end
        summary();
    end
endmodule